// File: doc/BRIEF.md
# Page Write Load Controller

This block is the write front end of a page-organised nonvolatile memory. A host issues byte loads with an active-low strobe, an address and a data byte. The block filters the strobe against short noise pulses. It takes the address when the filtered strobe goes low and the data when it goes high again. Bytes that belong to one page are collected in an on-chip page buffer. The low address bits pick the slot inside the page, and the upper bits name the page itself.

The load phase has no explicit commit. It closes on its own once no new byte has started for a fixed window. The block then runs a self-timed program cycle. It walks the page buffer in ascending slot order and hands each loaded byte to the array over a valid/ready port. Slots that were never loaded are skipped, so the array keeps their old contents. After the last slot it holds `busy` for a fixed settle time.

A byte that names a different page from the first byte of the load is dropped and flagged. Pulling `run_en` low blocks all loads and aborts any load or program cycle in progress.

Array port rules: `arr_valid` may rise at any time during the program cycle. Once `arr_valid` is high, `arr_addr` and `arr_data` hold steady until `arr_ready` is seen high on a clock edge. The only exception is `run_en` going low, which withdraws the request at once. The array may hold `arr_ready` low for as long as it needs, and the commit simply waits.

Top module: `pwl_page_loader`

## Requirements
- R1: After reset, with `ld_stb_n` high, `busy`, `page_err` and `arr_valid` are low.
- R2: A low pulse on `ld_stb_n` seen on fewer than FILT_CYC consecutive clock edges has no effect. A level change is recognised on the FILT_CYC-th consecutive edge that sees it.
- R3: `ld_addr` is taken on the edge where the filtered strobe falls, and `ld_data` on the edge where it rises. Values on these inputs at any other time have no effect.
- R4: The slot is `ld_addr[IDX_W-1:0]`, which is bits 6..0 by default, and the page is the bits above. If a slot is loaded twice within one load phase, the later data replaces the earlier data.
- R5: Suppose a strobe's page differs from the page of the first byte of the current load. Then `page_err` is high for exactly one cycle, the cycle after that strobe's filtered fall. The byte is not stored, and the load window is not restarted.
- R6: `busy` rises in the cycle after the first accepted filtered fall. The load phase closes WIN_CYC cycles after the most recent accepted filtered fall, provided that byte's data has been latched.
- R7: The program cycle requests only the loaded slots, in ascending slot order, with `arr_addr` = {page, slot}. It makes one transfer per valid/ready handshake, and addr and data stay stable while the request waits. Unloaded locations are never requested, so they keep their contents (an erased location reads 8'hFF).
- R8: After the last slot has been scanned, `busy` stays high for PROG_CYC more cycles. Strobes seen during the program and settle phases are ignored.
- R9: While `run_en` is low, strobes are ignored and `arr_valid` is low in the same cycle. `busy` is low from the next cycle on, and every byte collected so far is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 1 | Operation enable; low inhibits loads and aborts any load or program cycle |
| ld_stb_n | input | 1 | Host byte-load strobe, active low |
| ld_addr | input | ADDR_W | Load address: page in the upper bits, slot in the low bits |
| ld_data | input | DATA_W | Load data byte |
| busy | output | 1 | High from the first accepted byte until the program cycle ends |
| page_err | output | 1 | One-cycle pulse when a strobe names a foreign page |
| arr_valid | output | 1 | Array write request valid |
| arr_ready | input | 1 | Array accepts the request |
| arr_addr | output | ADDR_W | Array write address |
| arr_data | output | DATA_W | Array write data |

## Verification
Errors in the filter or the window timer show at the ports as an edge of `busy` that comes one or more cycles early or late. Per-cycle comparison against a behavioural model catches this on the very cycle it happens. A wrong loaded-slot record or a wrong scan index shows up as a missing, extra or reordered request on the array port, within 128 cycles after the load closes. A wrong stored byte or page only becomes visible in the data that reaches the array model. For that reason every scenario ends by reading back chosen locations, including unloaded neighbours that must still read 8'hFF. An abort that fails to clear the buffer leaves stale bytes behind, and these are caught when the array contents are read back later.

// File: rtl/pwl_pkg.sv
package pwl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOAD   = 2'd1,
    ST_PROG   = 2'd2,
    ST_SETTLE = 2'd3
  } pwl_state_e;
endpackage

// File: rtl/pwl_strobe_filter.sv
// Minimum-width filter on the active-low load strobe; emits one-cycle
// events on the edge where the filtered level changes.
module pwl_strobe_filter #(
  parameter int FILT_CYC = 3,
  localparam int CW = $clog2(FILT_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_n,
  output logic fall_ev,
  output logic rise_ev
);
  logic          lvl_q;
  logic [CW-1:0] cnt_q;
  logic          differ;
  logic          ripe;

  assign differ  = (stb_n != lvl_q);
  assign ripe    = differ && (cnt_q == CW'(FILT_CYC - 1));
  assign fall_ev = ripe && lvl_q;
  assign rise_ev = ripe && !lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= 1'b1;
      cnt_q <= '0;
    end else if (!differ) begin
      cnt_q <= '0;
    end else if (ripe) begin
      lvl_q <= stb_n;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_FILT_MATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_n == lvl_q) |=> (lvl_q == $past(lvl_q))); // R2
  AST_FILT_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != $past(lvl_q)) |-> (lvl_q == $past(stb_n))); // R2
endmodule

// File: rtl/pwl_page_buf.sv
// Page buffer: one data byte and one loaded flag per slot.
module pwl_page_buf #(
  parameter int PAGE_BYTES = 128,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_loaded
);
  logic [DATA_W-1:0]     data_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q;
  logic [PAGE_BYTES-1:0] hit;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_hit
    assign hit[g] = wr_en && (wr_idx == IDX_W'(g));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < PAGE_BYTES; i++) begin
      if (hit[i]) data_q[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) mask_q <= '0;
    else               mask_q <= mask_q | hit;
  end

  assign rd_data   = data_q[rd_idx];
  assign rd_loaded = mask_q[rd_idx];

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ($countones(mask_q) == 0)); // R9
  AST_WRITE_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> mask_q[$past(wr_idx)]); // R4
endmodule

// File: rtl/pwl_seq.sv
// Load/program sequencer: page check, load window, commit scan, settle.
module pwl_seq
  import pwl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int PAGE_BYTES = 128,
  parameter int WIN_CYC = 40,
  parameter int PROG_CYC = 200,
  localparam int IDX_W = $clog2(PAGE_BYTES),
  localparam int PG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              fall_ev,
  input  logic              rise_ev,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              arr_ready,
  input  logic              slot_loaded,
  output logic              busy,
  output logic              page_err,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic              clr,
  output logic [IDX_W-1:0]  scan_idx,
  output logic [PG_W-1:0]   page,
  output logic              arr_valid
);
  localparam int TW = $clog2(WIN_CYC + 1);
  localparam int PW = $clog2(PROG_CYC + 1);

  pwl_state_e       state_q;
  logic [PG_W-1:0]  page_q;
  logic [IDX_W-1:0] hold_idx_q;
  logic             pend_q;
  logic [TW-1:0]    tmr_q;
  logic [IDX_W-1:0] scan_q;
  logic [PW-1:0]    wcnt_q;
  logic             err_q;

  logic [PG_W-1:0]  pg_in;
  logic             same_pg;
  logic             acc_fall;
  logic             advance;
  logic             win_done;
  logic             settle_done;

  assign pg_in       = ld_addr[ADDR_W-1:IDX_W];
  assign same_pg     = (pg_in == page_q);
  assign acc_fall    = run_en && fall_ev &&
                       ((state_q == ST_IDLE) || ((state_q == ST_LOAD) && same_pg));
  assign win_done    = (tmr_q == TW'(WIN_CYC - 1)) && !pend_q;
  assign advance     = (state_q == ST_PROG) && (!slot_loaded || arr_ready);
  assign settle_done = (state_q == ST_SETTLE) && (wcnt_q == PW'(PROG_CYC - 1));

  assign wr_en     = run_en && rise_ev && pend_q;
  assign wr_idx    = hold_idx_q;
  assign clr       = !run_en || settle_done;
  assign scan_idx  = scan_q;
  assign page      = page_q;
  assign busy      = (state_q != ST_IDLE);
  assign page_err  = err_q;
  assign arr_valid = run_en && (state_q == ST_PROG) && slot_loaded;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      page_q     <= '0;
      hold_idx_q <= '0;
      pend_q     <= 1'b0;
      tmr_q      <= '0;
      scan_q     <= '0;
      wcnt_q     <= '0;
      err_q      <= 1'b0;
    end else if (!run_en) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q <= fall_ev && (state_q == ST_LOAD) && !same_pg;
      if (wr_en) pend_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (acc_fall) begin
            state_q    <= ST_LOAD;
            page_q     <= pg_in;
            hold_idx_q <= ld_addr[IDX_W-1:0];
            pend_q     <= 1'b1;
            tmr_q      <= '0;
          end
        end
        ST_LOAD: begin
          if (acc_fall) begin
            hold_idx_q <= ld_addr[IDX_W-1:0];
            pend_q     <= 1'b1;
            tmr_q      <= '0;
          end else if (win_done) begin
            state_q <= ST_PROG;
            scan_q  <= '0;
          end else if (tmr_q != TW'(WIN_CYC - 1)) begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        ST_PROG: begin
          if (advance) begin
            if (scan_q == IDX_W'(PAGE_BYTES - 1)) begin
              state_q <= ST_SETTLE;
              wcnt_q  <= '0;
            end else begin
              scan_q <= scan_q + 1'b1;
            end
          end
        end
        ST_SETTLE: begin
          if (settle_done) state_q <= ST_IDLE;
          else             wcnt_q  <= wcnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_BUSY_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(fall_ev)); // R6
  AST_HALT_ON_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !busy); // R9
  AST_ERR_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $past(state_q == ST_LOAD)); // R5
  AST_QUIET_WHILE_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_PROG) || (state_q == ST_SETTLE)) |-> !wr_en); // R8
endmodule

// File: rtl/pwl_page_loader.sv
module pwl_page_loader #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int PAGE_BYTES = 128,
  parameter int FILT_CYC = 3,
  parameter int WIN_CYC = 40,
  parameter int PROG_CYC = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              ld_stb_n,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  output logic              busy,
  output logic              page_err,
  output logic              arr_valid,
  input  logic              arr_ready,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data
);
  localparam int IDX_W = $clog2(PAGE_BYTES);
  localparam int PG_W = ADDR_W - IDX_W;

  logic             fall_ev, rise_ev;
  logic             wr_en, clr, slot_loaded;
  logic [IDX_W-1:0] wr_idx, scan_idx;
  logic [PG_W-1:0]  page;

  pwl_strobe_filter #(.FILT_CYC(FILT_CYC)) u_filt (
    .clk(clk), .rst_n(rst_n), .stb_n(ld_stb_n),
    .fall_ev(fall_ev), .rise_ev(rise_ev)
  );

  pwl_seq #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES),
    .WIN_CYC(WIN_CYC), .PROG_CYC(PROG_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .run_en(run_en),
    .fall_ev(fall_ev), .rise_ev(rise_ev), .ld_addr(ld_addr),
    .arr_ready(arr_ready), .slot_loaded(slot_loaded),
    .busy(busy), .page_err(page_err), .wr_en(wr_en), .wr_idx(wr_idx),
    .clr(clr), .scan_idx(scan_idx), .page(page), .arr_valid(arr_valid)
  );

  pwl_page_buf #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(ld_data), .clr(clr), .rd_idx(scan_idx),
    .rd_data(arr_data), .rd_loaded(slot_loaded)
  );

  assign arr_addr = {page, scan_idx};

  AST_ARR_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !run_en)
    (arr_valid && !arr_ready) |=> (arr_valid && $stable(arr_addr) && $stable(arr_data))); // R7
  AST_VALID_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    arr_valid |-> busy); // R7
endmodule

// File: tb/test_pwl_page_loader.sv
module test_pwl_page_loader;
  localparam int CLK_P = 10;
  localparam int AW = 17, DW = 8, PB = 128, IW = 7;
  localparam int FILT = 3, WIN = 40, PROG = 200;
  localparam int WDOG = 150000;

  logic clk, rst_n, run_en, ld_stb_n, arr_ready;
  logic [AW-1:0] ld_addr;
  logic [DW-1:0] ld_data;
  logic busy, page_err, arr_valid;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_data;

  int n_cmp = 0, n_bad = 0, cyc = 0, err_cnt = 0, rdy_mode = 1;
  logic [DW-1:0] mem [int];

  pwl_page_loader #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PB),
    .FILT_CYC(FILT), .WIN_CYC(WIN), .PROG_CYC(PROG)) i_pwl_page_loader (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .ld_stb_n(ld_stb_n),
    .ld_addr(ld_addr), .ld_data(ld_data), .busy(busy), .page_err(page_err),
    .arr_valid(arr_valid), .arr_ready(arr_ready), .arr_addr(arr_addr),
    .arr_data(arr_data));

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  function automatic int rd(int a);
    return mem.exists(a) ? int'(mem[a]) : 'hFF;
  endfunction

  // array model: erased state is all ones
  always @(posedge clk)
    if (rst_n && arr_valid && arr_ready) mem[int'(arr_addr)] = arr_data;

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      chk(0, "R1 watchdog", cyc, WDOG);
      summary();
      $finish;
    end
  end

  always @(negedge clk)
    case (rdy_mode)
      0: arr_ready = 1'b0;
      1: arr_ready = 1'b1;
      default: arr_ready = (cyc % 3) != 0;
    endcase

  // behavioural reference model, stepped on every rising edge
  int m_st = 0, m_fcnt = 0, m_tmr = 0, m_sidx = 0, m_wcnt = 0, m_idx = 0, m_page = 0;
  bit m_filt = 1, m_pend = 0, m_err = 0;
  bit m_mask [PB];
  int m_buf [PB];

  always @(posedge clk) begin
    bit fall, rise, differ, acc;
    int pg;
    if (!rst_n) begin
      m_filt = 1; m_fcnt = 0; m_st = 0; m_pend = 0; m_err = 0;
      m_tmr = 0; m_sidx = 0; m_wcnt = 0;
      foreach (m_mask[i]) m_mask[i] = 0;
    end else begin
      differ = (ld_stb_n != m_filt);
      fall = differ && (m_fcnt == FILT-1) && m_filt;
      rise = differ && (m_fcnt == FILT-1) && !m_filt;
      if (!differ) m_fcnt = 0;
      else if (m_fcnt == FILT-1) begin m_filt = ld_stb_n; m_fcnt = 0; end
      else m_fcnt++;
      pg = int'(ld_addr >> IW);
      if (!run_en) begin
        m_st = 0; m_pend = 0; m_err = 0;
        foreach (m_mask[i]) m_mask[i] = 0;
      end else begin
        m_err = 0;
        case (m_st)
          0: if (fall) begin
               m_st = 1; m_page = pg; m_idx = int'(ld_addr[IW-1:0]); m_pend = 1; m_tmr = 0;
             end
          1: begin
               acc = fall && (pg == m_page);
               if (fall && !acc) m_err = 1;
               if (acc) begin m_idx = int'(ld_addr[IW-1:0]); m_pend = 1; m_tmr = 0; end
               else if (m_tmr >= WIN-1 && !m_pend) begin m_st = 2; m_sidx = 0; end
               else if (m_tmr < WIN-1) m_tmr++;
               if (rise && m_pend && !acc) begin
                 m_buf[m_idx] = int'(ld_data); m_mask[m_idx] = 1; m_pend = 0;
               end
             end
          2: if (!m_mask[m_sidx] || arr_ready) begin
               if (m_sidx == PB-1) begin m_st = 3; m_wcnt = 0; end
               else m_sidx++;
             end
          default: if (m_wcnt == PROG-1) begin
                     m_st = 0;
                     foreach (m_mask[i]) m_mask[i] = 0;
                   end else m_wcnt++;
        endcase
      end
    end
  end

  // per-cycle comparison, away from the clock edges
  always begin
    bit ev;
    @(negedge clk); #2;
    if (page_err) err_cnt++;
    chk(busy == (m_st != 0), "R6 R8 busy", busy, m_st != 0);
    chk(page_err == m_err, "R5 page_err", page_err, m_err);
    ev = run_en && (m_st == 2) && m_mask[m_sidx];
    chk(arr_valid == ev, "R7 R9 arr_valid", arr_valid, ev);
    if (ev) begin
      chk(int'(arr_addr) == ((m_page << IW) | m_sidx), "R7 arr_addr",
          int'(arr_addr), (m_page << IW) | m_sidx);
      chk(int'(arr_data) == m_buf[m_sidx], "R7 arr_data", int'(arr_data), m_buf[m_sidx]);
    end
  end

  task automatic strobe(int a, int d, int lo, int hi);
    @(negedge clk);
    ld_addr = AW'(a); ld_data = DW'(d); ld_stb_n = 1'b0;
    repeat (lo) @(negedge clk);
    ld_stb_n = 1'b1;
    repeat (hi) @(negedge clk);
  endtask

  // address moves after the fall, data is valid only around the rise
  task automatic strobe_skew(int a, int d);
    @(negedge clk);
    ld_addr = AW'(a); ld_data = 8'h5A; ld_stb_n = 1'b0;
    repeat (4) @(negedge clk);
    ld_addr = AW'('h1_0000); ld_stb_n = 1'b1; ld_data = DW'(d);
    repeat (4) @(negedge clk);
    ld_data = 8'hC3;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; run_en = 1'b1; ld_stb_n = 1'b1; ld_addr = '0; ld_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk(busy == 0, "R1 busy", busy, 0);
    chk(page_err == 0, "R1 page_err", page_err, 0);
    chk(arr_valid == 0, "R1 arr_valid", arr_valid, 0);

    // R2: short pulse rejected
    strobe('h0205, 'h77, FILT-1, 6);
    repeat (50) @(negedge clk);
    #2 chk(busy == 0, "R2 glitch ignored", busy, 0);
    chk(rd('h0205) == 'hFF, "R2 glitch no write", rd('h0205), 'hFF);

    // R3 R4 R7: page 3, overwrite, skewed strobe, backpressure
    rdy_mode = 2;
    strobe('h185, 'h11, 4, 4);
    strobe('h181, 'h22, 4, 4);
    strobe('h185, 'h33, 4, 4);
    strobe_skew('h1FF, 'h44);
    strobe('h180, 'h55, 4, 4);
    wait_idle();
    chk(rd('h185) == 'h33, "R4 overwrite", rd('h185), 'h33);
    chk(rd('h181) == 'h22, "R4 slot 1", rd('h181), 'h22);
    chk(rd('h1FF) == 'h44, "R3 skewed capture", rd('h1FF), 'h44);
    chk(rd('h1_0000 | 'h7F) == 'hFF, "R3 late addr unused", rd('h1007F), 'hFF);
    chk(rd('h180) == 'h55, "R7 slot 0", rd('h180), 'h55);
    chk(rd('h182) == 'hFF, "R7 unloaded kept", rd('h182), 'hFF);

    // R5: foreign page dropped
    rdy_mode = 1;
    strobe('h104, 'h66, 4, 4);
    strobe('h484, 'h77, 4, 4);
    wait_idle();
    chk(err_cnt == 1, "R5 one error pulse", err_cnt, 1);
    chk(rd('h104) == 'h66, "R5 first page kept", rd('h104), 'h66);
    chk(rd('h484) == 'hFF, "R5 foreign byte dropped", rd('h484), 'hFF);

    // R8: strobe during program ignored
    rdy_mode = 2;
    strobe('h289, 'h12, 4, 4);
    repeat (50) @(negedge clk);
    strobe('h28A, 'h99, 4, 4);
    wait_idle();
    chk(rd('h289) == 'h12, "R8 committed", rd('h289), 'h12);
    chk(rd('h28A) == 'hFF, "R8 strobe ignored", rd('h28A), 'hFF);

    // R9: abort while request is pending
    rdy_mode = 0;
    strobe('h300, 'hA1, 4, 4);
    strobe('h301, 'hA2, 4, 4);
    repeat (60) @(negedge clk);
    #2 chk(arr_valid == 1, "R7 request held", arr_valid, 1);
    @(negedge clk);
    run_en = 1'b0;
    #2 chk(arr_valid == 0, "R9 request withdrawn", arr_valid, 0);
    @(negedge clk);
    #2 chk(busy == 0, "R9 busy drops", busy, 0);
    strobe('h380, 'hB1, 4, 4);
    repeat (50) @(negedge clk);
    #2 chk(busy == 0, "R9 strobe ignored", busy, 0);
    @(negedge clk);
    run_en = 1'b1; rdy_mode = 1;
    repeat (400) @(negedge clk);
    chk(rd('h300) == 'hFF, "R9 aborted slot 0", rd('h300), 'hFF);
    chk(rd('h301) == 'hFF, "R9 aborted slot 1", rd('h301), 'hFF);
    chk(rd('h380) == 'hFF, "R9 inhibited load", rd('h380), 'hFF);

    // R6: a later byte in the same page restarts the window
    strobe('h401, 'hC1, 4, 30);
    strobe('h402, 'hC2, 4, 4);
    wait_idle();
    chk(rd('h401) == 'hC1, "R6 first byte", rd('h401), 'hC1);
    chk(rd('h402) == 'hC2, "R6 late byte in window", rd('h402), 'hC2);

    summary();
    $finish;
  end
endmodule